// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer with External Wait

This block drives the access timing for a single chip select on an asynchronous external memory bus. An accepted request, either a read or a write, passes through three phases. In setup, the address is driven. In pulse, the read or write strobe is low. In hold, the strobe has returned high while the address stays put. The length of each phase comes from a timing configuration that is latched when the request is accepted. A write drives its data onto the bus for the whole access. A read captures the bus data on the last pulse cycle and returns it when the access completes.

The external device can stretch the strobe with an active-low wait pin. The pin passes through a two-flop synchronizer and is examined only while the strobe is in its pulse phase. A 2-bit mode field sets how the pin is used. The mode can disable the pin, freeze the pulse count while the pin is low, or keep the pulse going until the count has run out and the pin has been released. A configuration that enables wait but programs no hold cycle is refused with an error.

After a read, a programmable data-float count keeps the bus idle so that a slow device can release the data lines before the next access starts. Hold cycles that have already elapsed count toward the float time. Only the part of the float time that remains is added as idle cycles.

Top module: `xmem_cycle_seq`

## Requirements
- R1: While reset is high and on the first cycle after it: both strobes are high, the data output enable is low, done is low, request-ready is high and the captured read data is zero.
- R2: An accepted access lasts S setup cycles with both strobes high, then P pulse cycles with one strobe low, then H hold cycles, where S, P and H are the latched configuration values. A programmed P of 0 acts as 1. The address stays equal to the request address from setup through hold. Done is high for exactly one cycle, the cycle after the last hold cycle, or the cycle after the last pulse cycle when H is 0. The read and write strobes are never low together.
- R3: A read samples the data bus on its last pulse cycle. The sampled value appears on the read-data output by the done cycle and holds until the next read.
- R4: For a write, the output enable is high and the write-data output equals the request data from the first setup cycle through the last hold cycle. The output enable is low in every read and idle cycle.
- R5: Wait-mode values 00 and 01 disable the wait pin. In these modes the pulse lasts exactly P cycles, whatever the pin does.
- R6: Wait mode 10 freezes the pulse count. Each pulse cycle in which the synchronized pin is low adds one cycle to the pulse. The pin level in cycle k takes effect in cycle k+2.
- R7: Wait mode 11 is the ready mode. The pulse ends only after its P cycles have elapsed and the synchronized pin is high. A low pin that is released before the count runs out does not lengthen the pulse.
- R8: A low wait pin during setup, hold or idle cycles does not change any phase length.
- R9: A request made while the wait mode is 10 or 11 and the hold value is 0 gets request-error for one cycle. It starts no access and produces no done.
- R10: After a read with float count F and hold H, request-ready stays low for max(0, F-H) cycles counted from the done cycle. A write inserts no float cycles.
- R11: A request is accepted on a clock edge where request-valid and request-ready are both high and request-error is low. Request-ready is high only while no access is in progress and no float cycles remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Sequencer idle with no float cycles pending |
| req_err | output | 1 | Request refused because the configuration is illegal |
| cfg_setup | input | 4 | Setup cycles |
| cfg_pulse | input | 4 | Pulse cycles (0 acts as 1) |
| cfg_hold | input | 4 | Hold cycles |
| cfg_float | input | 4 | Data-float cycles after a read |
| cfg_wait_mode | input | 2 | 00/01 wait off, 10 frozen, 11 ready |
| mem_wait_n | input | 1 | Asynchronous active-low wait from the device |
| mem_addr | output | ADDR_W | Bus address |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_data_oe | output | 1 | Data bus output enable |
| mem_wdata | output | DATA_W | Data driven on the bus for writes |
| mem_rdata | input | DATA_W | Data bus input |
| rsp_rdata | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle access completion pulse |

## Verification
Reads and writes run with different setup, pulse and hold values, including zero setup, zero hold and a programmed pulse of zero, so that an off-by-one in any phase counter shows up. One wait pattern, low only during the early pulse cycles, is applied in both frozen and ready mode: frozen mode gives a longer pulse, while ready mode leaves it unchanged. A long low wait shows how ready mode stretches the pulse. Low wait confined to setup, to hold, or applied with the mode disabled must leave every phase length unchanged. Float counts above and below the hold value, and after a write, separate the float overlap with hold from a plain fixed delay.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int TIM_W = 4;

    typedef logic [TIM_W-1:0] tim_t;

    typedef enum logic [1:0] {
        WM_OFF    = 2'b00,
        WM_RSVD   = 2'b01,
        WM_FROZEN = 2'b10,
        WM_READY  = 2'b11
    } wait_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        tim_t       setup;
        tim_t       pulse;
        tim_t       hold;
        tim_t       flt;
        wait_mode_e mode;
    } timing_t;

    function automatic logic wait_enabled(wait_mode_e m);
        return m[1];
    endfunction

    function automatic logic cfg_illegal(timing_t c);
        return wait_enabled(c.mode) && (c.hold == '0);
    endfunction

    function automatic tim_t pulse_last(tim_t p);
        return (p == '0) ? '0 : p - tim_t'(1);
    endfunction

endpackage

// File: rtl/xmem_wait_sync.sv
module xmem_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= async_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/xmem_float_ctr.sv
module xmem_float_ctr
    import xmem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  tim_t load_val,
    output logic busy
);
    tim_t remain;

    always_ff @(posedge clk) begin
        if (rst)                remain <= '0;
        else if (load)          remain <= load_val;
        else if (remain != '0)  remain <= remain - tim_t'(1);
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/xmem_phase_fsm.sv
module xmem_phase_fsm
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  timing_t           cfg,
    input  logic              wait_s_n,
    input  logic              float_busy,
    output logic              req_ready,
    output logic              req_err,
    output phase_e            phase,
    output logic              cur_write,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              pulse_end,
    output tim_t              float_val,
    output logic              done
);
    timing_t tcfg;
    tim_t    cnt;
    logic    accept;
    logic    stall;

    always_comb begin
        req_ready = (phase == PH_IDLE) && !float_busy;
        req_err   = req_ready && req_valid && cfg_illegal(cfg);
        accept    = req_ready && req_valid && !cfg_illegal(cfg);
        stall     = wait_enabled(tcfg.mode) && !wait_s_n &&
                    ((tcfg.mode == WM_FROZEN) || (cnt == '0));
        pulse_end = (phase == PH_PULSE) && !stall && (cnt == '0);
        float_val = tcfg.flt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            tcfg      <= '0;
            cur_write <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        tcfg      <= cfg;
                        cur_write <= req_write;
                        cur_addr  <= req_addr;
                        cur_wdata <= req_wdata;
                        if (cfg.setup != '0) begin
                            phase <= PH_SETUP;
                            cnt   <= cfg.setup - tim_t'(1);
                        end else begin
                            phase <= PH_PULSE;
                            cnt   <= pulse_last(cfg.pulse);
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_PULSE;
                        cnt   <= pulse_last(tcfg.pulse);
                    end else begin
                        cnt <= cnt - tim_t'(1);
                    end
                end
                PH_PULSE: begin
                    if (!stall) begin
                        if (cnt != '0) begin
                            cnt <= cnt - tim_t'(1);
                        end else if (tcfg.hold != '0) begin
                            phase <= PH_HOLD;
                            cnt   <= tcfg.hold - tim_t'(1);
                        end else begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - tim_t'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R9: a refused request starts nothing
    a_r9_refused_stays_idle: assert property (@(posedge clk) disable iff (rst)
        req_err |=> (phase == PH_IDLE));

    // R6: frozen mode keeps pulse phase and count while wait is low
    a_r6_frozen_count_held: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PULSE && tcfg.mode == WM_FROZEN && !wait_s_n)
        |=> (phase == PH_PULSE && cnt == $past(cnt)));

    // R7: ready mode does not leave pulse while wait is low at count end
    a_r7_ready_holds_pulse: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PULSE && tcfg.mode == WM_READY && !wait_s_n && cnt == '0)
        |=> (phase == PH_PULSE));

    // R5: with wait disabled the pulse count always advances
    a_r5_off_counts_on: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PULSE && !tcfg.mode[1] && cnt != '0)
        |=> (phase == PH_PULSE && cnt == $past(cnt) - tim_t'(1)));
endmodule

// File: rtl/xmem_cycle_seq.sv
module xmem_cycle_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              req_err,
    input  logic [3:0]        cfg_setup,
    input  logic [3:0]        cfg_pulse,
    input  logic [3:0]        cfg_hold,
    input  logic [3:0]        cfg_float,
    input  logic [1:0]        cfg_wait_mode,
    input  logic              mem_wait_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              mem_data_oe,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              done
);
    timing_t cfg;
    phase_e  phase;
    logic    wait_s_n;
    logic    float_busy;
    logic    cur_write;
    logic    pulse_end;
    logic    rd_capture;
    tim_t    float_val;

    always_comb begin
        cfg.setup = cfg_setup;
        cfg.pulse = cfg_pulse;
        cfg.hold  = cfg_hold;
        cfg.flt   = cfg_float;
        cfg.mode  = wait_mode_e'(cfg_wait_mode);
    end

    xmem_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (mem_wait_n),
        .sync_n  (wait_s_n)
    );

    xmem_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .cfg        (cfg),
        .wait_s_n   (wait_s_n),
        .float_busy (float_busy),
        .req_ready  (req_ready),
        .req_err    (req_err),
        .phase      (phase),
        .cur_write  (cur_write),
        .cur_addr   (mem_addr),
        .cur_wdata  (mem_wdata),
        .pulse_end  (pulse_end),
        .float_val  (float_val),
        .done       (done)
    );

    assign rd_capture = pulse_end && !cur_write;

    xmem_float_ctr u_float (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_capture),
        .load_val (float_val),
        .busy     (float_busy)
    );

    always_ff @(posedge clk) begin
        if (rst)             rsp_rdata <= '0;
        else if (rd_capture) rsp_rdata <= mem_rdata;
    end

    always_comb begin
        mem_rd_n    = !((phase == PH_PULSE) && !cur_write);
        mem_wr_n    = !((phase == PH_PULSE) &&  cur_write);
        mem_data_oe = cur_write && (phase != PH_IDLE);
    end

    // R2: strobes are mutually exclusive
    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_n));

    // R4: the bus is never driven while reading
    a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |-> !mem_data_oe);

    // R2: done lasts a single cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: no acceptance while an access is in flight
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n || !mem_wr_n) |-> !req_ready);
endmodule

// File: tb/xmem_cycle_seq_bench.sv
module xmem_cycle_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam logic [DW-1:0] RD_KEY = 16'hC3A5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          req_err;
    logic [3:0]    cfg_setup = 4'd1;
    logic [3:0]    cfg_pulse = 4'd1;
    logic [3:0]    cfg_hold = 4'd1;
    logic [3:0]    cfg_float = 4'd0;
    logic [1:0]    cfg_wait_mode = 2'b00;
    logic          mem_wait_n = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_n;
    logic          mem_wr_n;
    logic          mem_data_oe;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] rsp_rdata;
    logic          done;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = !mem_rd_n ? (mem_addr ^ RD_KEY) : '0;

    xmem_cycle_seq u_xmem_cycle_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_err(req_err),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
        .cfg_float(cfg_float), .cfg_wait_mode(cfg_wait_mode),
        .mem_wait_n(mem_wait_n), .mem_addr(mem_addr),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_data_oe(mem_data_oe), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rsp_rdata(rsp_rdata), .done(done)
    );

    typedef struct {
        bit            w;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int            setup;
        int            plen;
        int            hold;
        string         tag;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   fails = 0;
    bit   finished = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: measures each access and compares with the scoreboard
    initial begin : monitor
        int t;
        int acc_t;
        int fall_t;
        int last_low;
        int plen;
        bit in_acc;
        t = 0; acc_t = 0; fall_t = 0; last_low = 0; plen = 0; in_acc = 0;
        forever begin
            @(negedge clk);
            #2;
            t++;
            if (!rst) begin
                if (done) begin
                    if (sbq.size() == 0) begin
                        chk(0, "R2", "done without access", 1, 0);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        chk(plen == e.plen, "R2", {e.tag, " pulse cycles"}, plen, e.plen);
                        chk(fall_t - acc_t - 1 == e.setup, "R2", {e.tag, " setup cycles"},
                            fall_t - acc_t - 1, e.setup);
                        chk(t - last_low - 1 == e.hold, "R2", {e.tag, " hold cycles"},
                            t - last_low - 1, e.hold);
                        if (!e.w)
                            chk(rsp_rdata == (e.addr ^ RD_KEY), "R3", {e.tag, " read data"},
                                rsp_rdata, e.addr ^ RD_KEY);
                    end
                    plen = 0;
                    in_acc = 0;
                end
                if ((!mem_rd_n || !mem_wr_n) && sbq.size() > 0) begin
                    if (plen == 0) fall_t = t;
                    plen++;
                    last_low = t;
                    chk(mem_addr == sbq[0].addr, "R2", "address during strobe",
                        mem_addr, sbq[0].addr);
                    chk((!mem_wr_n) == sbq[0].w, "R2", "strobe kind",
                        !mem_wr_n, sbq[0].w);
                    if (sbq[0].w)
                        chk(mem_wdata == sbq[0].data, "R4", "write data on bus",
                            mem_wdata, sbq[0].data);
                end
                if (in_acc && sbq.size() > 0)
                    chk(mem_data_oe == sbq[0].w, "R4", "output enable in access",
                        mem_data_oe, sbq[0].w);
                else
                    chk(mem_data_oe == 1'b0, "R4", "output enable while idle",
                        mem_data_oe, 0);
                if (req_valid && req_ready && !req_err) begin
                    acc_t = t;
                    in_acc = 1;
                end
            end
        end
    end

    task automatic access(bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                          int s, int p, int h, int f, logic [1:0] m,
                          int wlo, int whi, int exp_plen, int exp_block, string tag);
        exp_t e;
        bit   fin;
        int   blk;
        e.w = w; e.addr = a; e.data = d; e.setup = s;
        e.plen = exp_plen; e.hold = h; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        cfg_setup = 4'(s); cfg_pulse = 4'(p); cfg_hold = 4'(h);
        cfg_float = 4'(f); cfg_wait_mode = m;
        mem_wait_n = !(0 >= wlo && 0 < whi);
        #1;
        chk(req_ready == 1'b1 && req_err == 1'b0, "R11", {tag, " accepted"},
            req_ready, 1);
        fin = 0;
        for (int i = 1; i < 100 && !fin; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            mem_wait_n = !(i >= wlo && i < whi);
            #1;
            if (done) fin = 1;
        end
        chk(fin, "R2", {tag, " done seen"}, fin, 1);
        mem_wait_n = 1'b1;
        blk = 0;
        while (!req_ready && blk < 50) begin
            @(negedge clk);
            #1;
            blk++;
        end
        chk(blk == exp_block, "R10", {tag, " float idle cycles"}, blk, exp_block);
    endtask

    task automatic refused(string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0BAD;
        cfg_setup = 4'd1; cfg_pulse = 4'd2; cfg_hold = 4'd0;
        cfg_float = 4'd0; cfg_wait_mode = 2'b10;
        #1;
        chk(req_err == 1'b1, "R9", {tag, " error raised"}, req_err, 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(req_err == 1'b0, "R9", {tag, " error one cycle"}, req_err, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1;
            chk(mem_rd_n && mem_wr_n && !done && req_ready, "R9",
                {tag, " no access started"}, {mem_rd_n, mem_wr_n, done, req_ready}, 4'b1101);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        #1;
        chk(mem_rd_n && mem_wr_n && !mem_data_oe && !done, "R1", "outputs in reset",
            {mem_rd_n, mem_wr_n, mem_data_oe, done}, 4'b1100);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_rdata == '0, "R1", "read data after reset", rsp_rdata, 0);

        // R2 R3: plain read
        access(0, 16'h1234, '0, 2, 3, 1, 0, 2'b00, 0, 0, 3, 0, "rd_basic");
        // R4 R10: write ignores float
        access(1, 16'h2222, 16'hBEEF, 1, 2, 2, 3, 2'b00, 0, 0, 2, 0, "wr_basic");
        // R5: wait disabled in modes 00 and 01
        access(0, 16'h0301, '0, 1, 2, 1, 0, 2'b00, 0, 20, 2, 0, "off_wait_low");
        access(1, 16'h0302, 16'h5A5A, 1, 2, 1, 0, 2'b01, 0, 20, 2, 0, "rsvd_wait_low");
        // R6: frozen mode, two low cycles inside the pulse
        access(0, 16'h0601, '0, 1, 3, 1, 0, 2'b10, 2, 4, 5, 0, "frozen_mid");
        // R6 vs R7: same early wait pattern in each mode
        access(0, 16'h0602, '0, 1, 4, 1, 0, 2'b10, 0, 2, 6, 0, "frozen_early");
        access(0, 16'h0701, '0, 1, 4, 1, 0, 2'b11, 0, 2, 4, 0, "ready_early");
        // R7: ready mode stretched past the count
        access(1, 16'h0702, 16'h1357, 1, 2, 1, 0, 2'b11, 1, 5, 6, 0, "ready_long");
        // R8: wait low only in setup, then only in hold
        access(0, 16'h0801, '0, 3, 2, 2, 0, 2'b10, 0, 2, 2, 0, "wait_in_setup");
        access(0, 16'h0802, '0, 3, 2, 2, 0, 2'b11, 4, 6, 2, 0, "wait_in_hold");
        // R9: illegal configuration refused, then zero hold legal with wait off
        refused("zero_hold_wait");
        access(0, 16'h0901, '0, 0, 1, 0, 2, 2'b00, 0, 0, 1, 2, "zero_setup_hold");
        // R10: float larger and smaller than hold
        access(0, 16'h0A01, '0, 1, 1, 1, 5, 2'b00, 0, 0, 1, 4, "float_five");
        access(1, 16'h0A02, 16'hCAFE, 1, 1, 1, 0, 2'b00, 0, 0, 1, 0, "write_after_float");
        access(0, 16'h0A03, '0, 1, 2, 3, 2, 2'b00, 0, 0, 2, 0, "float_under_hold");
        // R2: programmed pulse of zero acts as one
        access(0, 16'h0B01, '0, 1, 0, 1, 0, 2'b00, 0, 0, 1, 0, "pulse_zero");

        repeat (3) @(negedge clk);
        #1;
        chk(sbq.size() == 0, "R2", "all accesses completed", sbq.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule